// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block reads a run of bytes from a four-wire serial EEPROM by driving the pins one control step at a time. Two separate lines gate access to the memory, one active high and one active low. A clock, a data output and a data input carry the bits. A request gives a 16-bit logical offset, a byte count and a base offset. The block opens access, sends the read opcode and a 16-bit address, then clocks in the requested bytes. Each byte is handed out with a one-cycle valid strobe. Access is then closed and the block pulses done.

A request is refused, with a one-cycle error pulse and no pin activity, in three cases: the memory is reported absent, the memory is not reported present, or the base offset does not fit in 16 bits. Every pin step (open, close, data setup, clock high, clock low) is held for `PHASE_CYC` system clocks.

Top module: `eeprom_rd_seq`

## Requirements
- R1: Out of reset and while idle: acc_hi=0, acc_lo=1, ee_sclk=0, ee_sdo=0, busy=0, byte_vld=0, done=0, err=0.
- R2: Opening access takes two separate updates. acc_hi rises while acc_lo is still 1. acc_lo falls PHASE_CYC cycles later, while acc_hi is 1.
- R3: Every accepted transaction ends by closing access. acc_lo rises while acc_hi is still 1. acc_hi falls PHASE_CYC cycles later, while acc_lo is 1.
- R4: After access is open, the first 24 bits sent on ee_sdo are the opcode 0x03, then the address high byte, then the address low byte. Each byte goes out most significant bit first, one bit per rising ee_sclk.
- R5: The address sent equals (rd_offset + base_offset) modulo 65536.
- R6: If base_offset is 65536 or more, err pulses for one cycle. busy stays low and no access line or clock moves.
- R7: If nvm_present=0 or nvm_absent=1 at the start, err pulses for one cycle. busy stays low and no access line or clock moves.
- R8: For each bit sent, ee_sdo is steady for at least PHASE_CYC cycles before ee_sclk rises and does not change while ee_sclk is high. Each clock high pulse lasts exactly PHASE_CYC cycles. ee_sclk only toggles while access is open.
- R9: On input, ee_sdi is sampled while ee_sclk is high. Bits are assembled most significant bit first. Each completed byte appears on byte_data with a one-cycle byte_vld pulse.
- R10: Exactly rd_count bytes are read, using 8 clock pulses each. With rd_count=0, only the 24 command/address clocks occur before access is closed.
- R11: busy is high from the cycle after an accepted start until access is closed. done pulses for one cycle as busy falls. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| rd_offset | input | 16 | Logical byte offset |
| rd_count | input | CNT_W | Number of bytes to read |
| base_offset | input | BASE_W | Offset added to rd_offset; must fit in 16 bits |
| nvm_present | input | 1 | Memory present flag |
| nvm_absent | input | 1 | Memory absent flag |
| ee_sdi | input | 1 | Serial data from memory |
| acc_hi | output | 1 | Active-high access line |
| acc_lo | output | 1 | Active-low access line |
| ee_sclk | output | 1 | Serial clock |
| ee_sdo | output | 1 | Serial data to memory |
| busy | output | 1 | Transaction in progress |
| byte_vld | output | 1 | byte_data is valid this cycle |
| byte_data | output | 8 | Received byte |
| done | output | 1 | Transaction finished |
| err | output | 1 | Request refused |

## Verification
The assertions assume that reset is applied before the first request. They place no condition on ee_sdi or on the request fields, because those fields are captured only in the accept cycle. The memory model in the bench changes ee_sdi only on a falling ee_sclk, so the data bit is settled for the whole high phase. Requests are driven on the falling system clock and held for one cycle. The busy-time start is issued well inside an open session.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  localparam logic [7:0] RD_OPCODE = 8'h03;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPEN_HI, ST_OPEN_LO, ST_CMD, ST_ADR_H,
    ST_ADR_L, ST_DATA, ST_CLOSE_LO, ST_CLOSE_HI
  } seq_state_t;

  typedef enum logic [1:0] {SH_IDLE, SH_SETUP, SH_HIGH, SH_LOW} sh_state_t;

  // Sum of the logical offset and the low half of the base; carry out dropped.
  function automatic logic [15:0] wire_addr(input logic [15:0] off,
                                            input logic [15:0] base_lo);
    return off + base_lo;
  endfunction

  // Byte sent in each transmit state; receive state sends nothing.
  function automatic logic [7:0] tx_pick(input seq_state_t st,
                                         input logic [15:0] addr);
    case (st)
      ST_CMD:  return RD_OPCODE;
      ST_ADR_H: return addr[15:8];
      ST_ADR_L: return addr[7:0];
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/eeprom_rd_timer.sv
module eeprom_rd_timer #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(PHASE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || expire)    cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eeprom_rd_shifter.sv
module eeprom_rd_shifter
  import eeprom_rd_pkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       rx_mode,
  input  logic [7:0] tx_byte,
  input  logic       sdi,
  output logic       sclk,
  output logic       sdo,
  output logic       fin,
  output logic [7:0] rx_byte
);
  sh_state_t  st;
  logic [7:0] sr;
  logic [2:0] bit_idx;
  logic       dir_rx;
  logic       ph_end;

  eeprom_rd_timer #(.PHASE_CYC(PHASE_CYC)) u_ph_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st != SH_IDLE),
    .expire (ph_end)
  );

  assign sclk    = (st == SH_HIGH);
  assign sdo     = (st != SH_IDLE) && !dir_rx && sr[7];
  assign fin     = (st == SH_LOW) && ph_end && (bit_idx == 3'd7);
  assign rx_byte = sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SH_IDLE;
      sr      <= '0;
      bit_idx <= '0;
      dir_rx  <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: if (go) begin
          sr      <= tx_byte;
          bit_idx <= '0;
          dir_rx  <= rx_mode;
          st      <= rx_mode ? SH_HIGH : SH_SETUP;
        end
        SH_SETUP: if (ph_end) st <= SH_HIGH;
        SH_HIGH: if (ph_end) begin
          if (dir_rx) sr <= {sr[6:0], sdi};
          st <= SH_LOW;
        end
        SH_LOW: if (ph_end) begin
          if (!dir_rx) sr <= {sr[6:0], 1'b0};
          if (bit_idx == 3'd7) st <= SH_IDLE;
          else begin
            bit_idx <= bit_idx + 3'd1;
            st      <= dir_rx ? SH_HIGH : SH_SETUP;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  // R8: data line held while the clock is high
  p_sdo_steady_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));

  // R4: the sequencer only launches a byte into an idle shifter
  p_go_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == SH_IDLE));
endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
  import eeprom_rd_pkg::*;
#(
  parameter int PHASE_CYC = 4,
  parameter int CNT_W     = 16,
  parameter int BASE_W    = 32   // at least 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       rd_offset,
  input  logic [CNT_W-1:0]  rd_count,
  input  logic [BASE_W-1:0] base_offset,
  input  logic              nvm_present,
  input  logic              nvm_absent,
  input  logic              ee_sdi,
  output logic              acc_hi,
  output logic              acc_lo,
  output logic              ee_sclk,
  output logic              ee_sdo,
  output logic              busy,
  output logic              byte_vld,
  output logic [7:0]        byte_data,
  output logic              done,
  output logic              err
);
  seq_state_t       st;
  logic [15:0]      addr_q;
  logic [CNT_W-1:0] left_q;
  logic             issued;

  // named internal events
  logic base_fits, req_accept, req_bad, req_go, req_fail;
  logic acc_phase, byte_phase, acc_tick;
  logic sh_go, sh_fin, sh_rx_mode;
  logic [7:0] sh_tx, sh_rx;

  assign base_fits  = ~|(base_offset >> 16);
  assign req_accept = start && (st == ST_IDLE);
  assign req_bad    = !nvm_present || nvm_absent || !base_fits;
  assign req_go     = req_accept && !req_bad;
  assign req_fail   = req_accept && req_bad;

  assign acc_phase  = (st == ST_OPEN_HI) || (st == ST_OPEN_LO) ||
                      (st == ST_CLOSE_LO) || (st == ST_CLOSE_HI);
  assign byte_phase = (st == ST_CMD) || (st == ST_ADR_H) ||
                      (st == ST_ADR_L) || (st == ST_DATA);

  assign sh_go      = byte_phase && !issued;
  assign sh_rx_mode = (st == ST_DATA);
  assign sh_tx      = tx_pick(st, addr_q);

  eeprom_rd_timer #(.PHASE_CYC(PHASE_CYC)) u_acc_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (acc_phase),
    .expire (acc_tick)
  );

  eeprom_rd_shifter #(.PHASE_CYC(PHASE_CYC)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (sh_go),
    .rx_mode (sh_rx_mode),
    .tx_byte (sh_tx),
    .sdi     (ee_sdi),
    .sclk    (ee_sclk),
    .sdo     (ee_sdo),
    .fin     (sh_fin),
    .rx_byte (sh_rx)
  );

  assign acc_hi = (st != ST_IDLE) && (st != ST_CLOSE_HI);
  assign acc_lo = (st == ST_IDLE) || (st == ST_OPEN_HI) ||
                  (st == ST_CLOSE_LO) || (st == ST_CLOSE_HI);
  assign busy   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      left_q    <= '0;
      issued    <= 1'b0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      byte_vld <= sh_fin && (st == ST_DATA);
      if (sh_fin && (st == ST_DATA)) byte_data <= sh_rx;
      done <= (st == ST_CLOSE_HI) && acc_tick;
      err  <= req_fail;

      if (sh_fin)     issued <= 1'b0;
      else if (sh_go) issued <= 1'b1;

      case (st)
        ST_IDLE: if (req_go) begin
          addr_q <= wire_addr(rd_offset, base_offset[15:0]);
          left_q <= rd_count;
          st     <= ST_OPEN_HI;
        end
        ST_OPEN_HI:  if (acc_tick) st <= ST_OPEN_LO;
        ST_OPEN_LO:  if (acc_tick) st <= ST_CMD;
        ST_CMD:      if (sh_fin)   st <= ST_ADR_H;
        ST_ADR_H:    if (sh_fin)   st <= ST_ADR_L;
        ST_ADR_L:    if (sh_fin)   st <= (left_q == '0) ? ST_CLOSE_LO : ST_DATA;
        ST_DATA: if (sh_fin) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) st <= ST_CLOSE_LO;
        end
        ST_CLOSE_LO: if (acc_tick) st <= ST_CLOSE_HI;
        ST_CLOSE_HI: if (acc_tick) st <= ST_IDLE;
        default:     st <= ST_IDLE;
      endcase
    end
  end

  // R2: open ordering
  p_open_hi_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_hi) |-> acc_lo);
  p_open_lo_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_lo) |-> acc_hi);
  // R3: close ordering
  p_close_lo_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_lo) |-> acc_hi);
  p_close_hi_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_hi) |-> acc_lo);
  // R8: clock only moves inside an open session
  p_clock_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sclk |-> (acc_hi && !acc_lo));
  // R6 / R7: a refused request leaves the pins alone
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !acc_hi && acc_lo));
  // R9: received bytes only inside a session
  p_vld_in_session_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> busy);
  // R10: receive state never entered with nothing left
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> (left_q != '0));
  // R11: done marks the end of a session and never coincides with err
  p_done_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !err));
endmodule

// File: tb/eeprom_rd_seq_test.sv
module eeprom_rd_seq_test;
  localparam int PH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] rd_offset = '0;
  logic [15:0] rd_count = '0;
  logic [31:0] base_offset = '0;
  logic        nvm_present = 1'b1;
  logic        nvm_absent = 1'b0;
  logic        ee_sdi;
  logic        acc_hi, acc_lo, ee_sclk, ee_sdo, busy, byte_vld, done, err;
  logic [7:0]  byte_data;

  always #2 clk = ~clk;

  eeprom_rd_seq #(.PHASE_CYC(PH)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_offset(rd_offset),
    .rd_count(rd_count), .base_offset(base_offset), .nvm_present(nvm_present),
    .nvm_absent(nvm_absent), .ee_sdi(ee_sdi), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .ee_sclk(ee_sclk), .ee_sdo(ee_sdo), .busy(busy), .byte_vld(byte_vld),
    .byte_data(byte_data), .done(done), .err(err)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory content used by the model
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return {a[6:0], a[7]} ^ a[15:8] ^ 8'hA5;
  endfunction

  // ---------------- memory model ----------------
  int          rises = 0, falls = 0, closed_rises = 0;
  logic [23:0] hdr = '0;

  function automatic logic model_bit(input int f, input logic [15:0] a);
    int j;
    logic [7:0] b;
    if (f < 24) return 1'b0;
    j = f - 24;
    b = mem_byte(a + 16'(j / 8));
    return b[7 - (j % 8)];
  endfunction

  assign ee_sdi = model_bit(falls, hdr[15:0]);

  always @(posedge ee_sclk) begin
    if (!(acc_hi && !acc_lo)) closed_rises = closed_rises + 1;
    if (rises < 24) hdr = {hdr[22:0], ee_sdo};
    rises = rises + 1;
  end
  always @(negedge ee_sclk) falls = falls + 1;

  // ---------------- pin monitor ----------------
  int   cyc = 0;
  int   t_hi_up = -1, t_lo_dn = -1, t_lo_up = -1, t_hi_dn = -1;
  int   order_bad = 0, tmg_bad = 0, hi_len = 0, sdo_age = 0;
  logic p_hi = 1'b0, p_lo = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;
  logic [7:0] got [0:15];
  int   nget = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (acc_hi && !p_hi) begin t_hi_up = cyc; if (!acc_lo) order_bad++; end
      if (!acc_lo && p_lo) begin t_lo_dn = cyc; if (!acc_hi) order_bad++; end
      if (acc_lo && !p_lo) begin t_lo_up = cyc; if (!acc_hi) order_bad++; end
      if (!acc_hi && p_hi) begin t_hi_dn = cyc; if (!acc_lo) order_bad++; end
      if (ee_sdo != p_sdo) sdo_age = 0; else sdo_age = sdo_age + 1;
      if (ee_sclk && !p_sclk && rises <= 24 && sdo_age < PH) tmg_bad++;
      if (ee_sclk && p_sclk && ee_sdo != p_sdo) tmg_bad++;
      if (ee_sclk) hi_len = hi_len + 1;
      else if (p_sclk) begin
        if (hi_len != PH) tmg_bad++;
        hi_len = 0;
      end
      if (byte_vld && nget < 16) begin got[nget] = byte_data; nget++; end
    end
    p_hi = acc_hi; p_lo = acc_lo; p_sclk = ee_sclk; p_sdo = ee_sdo;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic clear_mon();
    rises = 0; falls = 0; closed_rises = 0; hdr = '0; nget = 0;
    t_hi_up = -1; t_lo_dn = -1; t_lo_up = -1; t_hi_dn = -1;
    order_bad = 0; tmg_bad = 0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_err,
                          output int busy_drop);
    got_done = 0; got_err = 0; busy_drop = 0;
    for (int i = 0; i < 40000; i++) begin
      if (done) begin got_done = 1; break; end
      if (err)  begin got_err = 1; break; end
      if (!busy) busy_drop++;
      @(negedge clk);
    end
  endtask

  task automatic launch(input logic [15:0] off, input logic [15:0] n,
                        input logic [31:0] b, input logic pres, input logic abs_f);
    clear_mon();
    @(negedge clk);
    rd_offset = off; rd_count = n; base_offset = b;
    nvm_present = pres; nvm_absent = abs_f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_read(input string tag, input logic [15:0] off,
                        input logic [15:0] n, input logic [31:0] b);
    bit gd, ge; int bd;
    logic [15:0] ea;
    ea = off + b[15:0];
    launch(off, n, b, 1'b1, 1'b0);
    chk(busy == 1'b1, "R11", {tag, " busy after start"}, busy, 1);
    wait_end(gd, ge, bd);
    chk(gd && !ge, "R11", {tag, " done seen"}, {gd, ge}, 2'b10);
    chk(bd == 0, "R11", {tag, " busy held"}, bd, 0);
    chk(!busy && !acc_hi && acc_lo, "R3", {tag, " closed at done"},
        {busy, acc_hi, acc_lo}, 3'b001);
    chk(hdr[23:16] == 8'h03, "R4", {tag, " opcode"}, hdr[23:16], 8'h03);
    chk(hdr[15:0] == ea, "R5", {tag, " address"}, hdr[15:0], ea);
    chk(t_hi_up > 0 && t_lo_dn - t_hi_up == PH, "R2", {tag, " open spacing"},
        t_lo_dn - t_hi_up, PH);
    chk(t_lo_up > 0 && t_hi_dn - t_lo_up == PH, "R3", {tag, " close spacing"},
        t_hi_dn - t_lo_up, PH);
    chk(order_bad == 0, "R2", {tag, " access order"}, order_bad, 0);
    chk(tmg_bad == 0, "R8", {tag, " bit timing"}, tmg_bad, 0);
    chk(closed_rises == 0, "R8", {tag, " clock gated"}, closed_rises, 0);
    chk(rises == 24 + 8 * int'(n), "R10", {tag, " clock count"}, rises, 24 + 8 * int'(n));
    chk(nget == int'(n), "R10", {tag, " byte count"}, nget, n);
    for (int i = 0; i < nget; i++)
      chk(got[i] == mem_byte(ea + 16'(i)), "R9", {tag, " data byte"},
          got[i], mem_byte(ea + 16'(i)));
  endtask

  task automatic t_refuse(input string tag, input string req, input logic [31:0] b,
                          input logic pres, input logic abs_f);
    bit gd, ge; int bd;
    launch(16'h0040, 16'd2, b, pres, abs_f);
    chk(err == 1'b1 && busy == 1'b0, req, {tag, " err pulse"}, {err, busy}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0, req, {tag, " err one cycle"}, err, 0);
    wait_end(gd, ge, bd);
    chk(!gd, req, {tag, " no done"}, gd, 0);
    chk(t_hi_up == -1 && rises == 0, req, {tag, " pins untouched"}, rises, 0);
    nvm_present = 1'b1; nvm_absent = 1'b0; base_offset = '0;
  endtask

  task automatic t_busy_ignore();
    bit gd, ge; int bd;
    launch(16'h0100, 16'd1, 32'h0, 1'b1, 1'b0);
    repeat (60) @(negedge clk);
    rd_offset = 16'h7777; rd_count = 16'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end(gd, ge, bd);
    chk(gd, "R11", "ignored start: done", gd, 1);
    chk(hdr[15:0] == 16'h0100, "R11", "ignored start: address kept", hdr[15:0], 16'h0100);
    chk(nget == 1, "R11", "ignored start: count kept", nget, 1);
    repeat (20) @(negedge clk);
    chk(!busy, "R11", "no second session", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!acc_hi && acc_lo && !ee_sclk && !ee_sdo && !busy && !byte_vld && !done && !err,
        "R1", "reset state",
        {acc_hi, acc_lo, ee_sclk, ee_sdo, busy, byte_vld, done, err}, 8'b01000000);
    t_read("plain", 16'h0010, 16'd3, 32'h0000_0100);
    t_read("wrap", 16'hFFF0, 16'd2, 32'h0000_0020);
    t_read("highaddr", 16'h12C5, 16'd4, 32'h0000_8000);
    t_read("zero", 16'h0A0A, 16'd0, 32'h0);
    t_refuse("bigbase", "R6", 32'h0001_0000, 1'b1, 1'b0);
    t_refuse("nopresent", "R7", 32'h0, 1'b0, 1'b0);
    t_refuse("absent", "R7", 32'h0, 1'b1, 1'b1);
    t_busy_ignore();
    @(negedge clk);
    chk(!acc_hi && acc_lo && !busy, "R1", "idle at end", {acc_hi, acc_lo, busy}, 3'b010);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule